// File: doc/BRIEF.md
# Buffered Row Programming Controller for a Small Non-Volatile Data Array

This block sits between a CPU bus and a 128-byte non-volatile data array. The array is organised as rows of 32 bytes. Software first sets a latch-mode bit in a small control/status register. Bus writes then fill a bank of byte latches instead of reaching the array. Setting the program bit starts a timed cycle that first erases and then writes the latched byte positions of one row. The row is the one addressed by the most recent latch write. In this model the cell array is a plain register array, and a clock counter stands in for the charge-pump timing.

While latch mode is off, the array reads like ordinary memory and bus writes are dropped. While it is on, array reads leave the data bus undriven, and the latches can never be read back. Repeated writes to one latch before it is cleared combine by bitwise AND. The block also handles a wait request, which waits for a running cycle to finish, and a halt request, which aborts a cycle at once and marks the affected row as undefined. A readout-protect input forces every array read to return zero.

Top module: `eeprom_row_writer`

## Requirements
- R1: After reset, csr_rdata is 00h, rd_oe is 0, in_wait is 0, halted is 0 and row_undef is all zero.
- R2: The control/status register maps the program bit to bit 0 and the latch-mode bit to bit 1. Bits 7:2 always read 0.
- R3: With the latch-mode bit at 0, a bus read returns the stored byte with rd_oe=1 on the cycle after the request, and a bus write leaves the array unchanged.
- R4: With the latch-mode bit at 1, a bus read gives rd_oe=0 and rd_data=00h, so latched data is never visible.
- R5: Writing 1 to bit 0 while the latch-mode bit is 0 does not set the program bit.
- R6: Writing 1 to bit 0 while the latch-mode bit is 1 sets the program bit for exactly CYC_CLKS cycles. Hardware then clears the program and latch-mode bits in the same clock. Only latched byte positions change, in the row given by address bits 6:5 of the last latch write, and the latch index is address bits 4:0.
- R7: Two writes to the same latch before it is cleared store the bitwise AND of the two values.
- R8: A software clear of the latch-mode bit (a falling edge) empties all latches, so an earlier latch write is not programmed later.
- R9: While the program bit is 1, control/status writes are ignored, including an attempt to clear the latch-mode bit.
- R10: A wait request sets in_wait on the next clock when the controller is idle. During a cycle, in_wait rises on the clock that ends the cycle. While in_wait is 1, bus and control/status accesses are ignored.
- R11: A halt request aborts a running cycle on the next clock. That clock clears both bits and sets the row_undef bit of the target row. halted follows halt_req one clock later, and a later complete cycle on that row clears its row_undef bit.
- R12: With ro_protect at 1, a bus read returns rd_data=00h with rd_oe=1.
- R13: A cycle aborted after its erase phase, which is the first ERASE_CLKS clocks, leaves the latched positions at FFh. One aborted before the erase phase ends leaves the row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Array access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address: bits 6:5 row, bits 4:0 byte in row |
| bus_wdata | input | 8 | Write data |
| rd_oe | output | 1 | Read data driven (registered) |
| rd_data | output | 8 | Read data (registered) |
| csr_we | input | 1 | Control/status register write strobe |
| csr_wdata | input | 8 | Control/status register write data |
| csr_rdata | output | 8 | Control/status register value |
| ro_protect | input | 1 | Readout protection: reads return 00h |
| wait_req | input | 1 | Wait request (level) |
| in_wait | output | 1 | Controller in wait |
| halt_req | input | 1 | Halt request (level) |
| halted | output | 1 | Controller halted |
| row_undef | output | 4 | Per-row flag: contents undefined after an abort |

## Verification
Read results appear on rd_oe and rd_data one clock after the request edge. A register write or a halt request takes effect on csr_rdata, halted and row_undef one clock after its edge. A cycle started at edge E0 keeps the program bit set through the clocks up to edge E0+CYC_CLKS, and at that edge the program bit, the latch-mode bit and, under a pending wait, in_wait all change together. The erase takes effect at edge E0+ERASE_CLKS. The bench drives every input on the falling edge and samples on the next falling edge, so each check lands a fixed number of whole cycles after its stimulus. Halt is injected on both sides of the erase boundary to pin down that timing.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int CSR_PGM_BIT = 0;
  localparam int CSR_LAT_BIT = 1;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_WRITE = 2'd2
  } prog_phase_e;
endpackage

// File: rtl/eep_seq.sv
module eep_seq #(
  parameter int CYC_CLKS   = 16,
  parameter int ERASE_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csr_we,
  input  logic [7:0] csr_wdata,
  input  logic       wait_req,
  input  logic       halt_req,
  output logic       lat_q,
  output logic       pgm,
  output logic       in_wait,
  output logic       halted,
  output logic       acc_ok,
  output logic       erase_stb,
  output logic       commit_stb,
  output logic       abort_stb,
  output logic       clr_latches
);
  import eep_pkg::*;
  localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CLKS - 1);
  localparam logic [CNT_W-1:0] CYC_LAST   = CNT_W'(CYC_CLKS - 1);

  prog_phase_e      phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lat_d;
  logic             csr_take, start;

  assign acc_ok     = !in_wait && !halted;
  assign csr_take   = csr_we && acc_ok && (phase_q == PH_IDLE);
  assign start      = csr_take && csr_wdata[CSR_PGM_BIT] && lat_q;
  assign abort_stb  = halt_req && (phase_q != PH_IDLE);
  assign erase_stb  = !abort_stb && (phase_q == PH_ERASE) && (cnt_q == ERASE_LAST);
  assign commit_stb = !abort_stb && (phase_q == PH_WRITE) && (cnt_q == CYC_LAST);
  assign pgm        = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    if (abort_stb) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      lat_d   = 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d = PH_ERASE;
        cnt_d   = '0;
      end else if (csr_take) begin
        lat_d = csr_wdata[CSR_LAT_BIT];
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
      if (erase_stb) phase_d = PH_WRITE;
      if (commit_stb) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        lat_d   = 1'b0;
      end
    end
  end

  assign clr_latches = lat_q && !lat_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      lat_q   <= 1'b0;
      in_wait <= 1'b0;
      halted  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
      in_wait <= wait_req && (phase_d == PH_IDLE);
      halted  <= halt_req;
    end
  end
endmodule

// File: rtl/eep_latch_bank.sv
module eep_latch_bank #(
  parameter int NBYTES = 32,
  parameter int ROW_W  = 2,
  localparam int OFF_W = $clog2(NBYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [OFF_W-1:0]    off,
  input  logic [ROW_W-1:0]    row,
  input  logic [7:0]          wdata,
  input  logic                clr,
  output logic [NBYTES*8-1:0] lat_data,
  output logic [NBYTES-1:0]   lat_mask,
  output logic [ROW_W-1:0]    tgt_row
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        lat_mask[i]         <= 1'b0;
        lat_data[i*8 +: 8]  <= 8'hFF;
      end else if (wr && (off == OFF_W'(i))) begin
        lat_mask[i]         <= 1'b1;
        lat_data[i*8 +: 8]  <= lat_mask[i] ? (lat_data[i*8 +: 8] & wdata) : wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tgt_row <= '0;
    else if (wr) tgt_row <= row;
  end
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
  parameter int ROWS   = 4,
  parameter int NBYTES = 32,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                clk,
  input  logic [NBYTES-1:0]   we,
  input  logic [ROW_W-1:0]    waddr,
  input  logic [NBYTES*8-1:0] wdata,
  input  logic [ROW_W-1:0]    raddr,
  output logic [NBYTES*8-1:0] rdata
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [7:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (we[i]) mem[waddr] <= wdata[i*8 +: 8];
    end
    assign rdata[i*8 +: 8] = mem[raddr];
  end
endmodule

// File: rtl/eeprom_row_writer.sv
module eeprom_row_writer #(
  parameter int ROWS       = 4,
  parameter int NBYTES     = 32,
  parameter int CYC_CLKS   = 16,
  parameter int ERASE_CLKS = 8,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int OFF_W  = $clog2(NBYTES),
  localparam int ADDR_W = ROW_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              rd_oe,
  output logic [7:0]        rd_data,
  input  logic              csr_we,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              ro_protect,
  input  logic              wait_req,
  output logic              in_wait,
  input  logic              halt_req,
  output logic              halted,
  output logic [ROWS-1:0]   row_undef
);
  import eep_pkg::*;

  logic lat_q, pgm, acc_ok, erase_stb, commit_stb, abort_stb, clr_latches;
  logic latch_wr, bus_rd;
  logic [NBYTES*8-1:0] lat_data, arr_wdata, arr_rdata;
  logic [NBYTES-1:0]   lat_mask, arr_we;
  logic [ROW_W-1:0]    tgt_row;
  logic [ROW_W-1:0]    a_row;
  logic [OFF_W-1:0]    a_off;

  assign a_row = bus_addr[ADDR_W-1:OFF_W];
  assign a_off = bus_addr[OFF_W-1:0];

  eep_seq #(.CYC_CLKS(CYC_CLKS), .ERASE_CLKS(ERASE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .wait_req(wait_req), .halt_req(halt_req), .lat_q(lat_q), .pgm(pgm),
    .in_wait(in_wait), .halted(halted), .acc_ok(acc_ok),
    .erase_stb(erase_stb), .commit_stb(commit_stb), .abort_stb(abort_stb),
    .clr_latches(clr_latches)
  );

  assign latch_wr = bus_en && bus_wr && lat_q && !pgm && acc_ok;
  assign bus_rd   = bus_en && !bus_wr && acc_ok;

  eep_latch_bank #(.NBYTES(NBYTES), .ROW_W(ROW_W)) u_latch (
    .clk(clk), .rst(rst), .wr(latch_wr), .off(a_off), .row(a_row),
    .wdata(bus_wdata), .clr(clr_latches), .lat_data(lat_data),
    .lat_mask(lat_mask), .tgt_row(tgt_row)
  );

  assign arr_we    = (erase_stb || commit_stb) ? lat_mask : '0;
  assign arr_wdata = erase_stb ? {NBYTES{ERASED_BYTE}} : lat_data;

  eep_cell_array #(.ROWS(ROWS), .NBYTES(NBYTES)) u_arr (
    .clk(clk), .we(arr_we), .waddr(tgt_row), .wdata(arr_wdata),
    .raddr(a_row), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe   <= 1'b0;
      rd_data <= 8'h00;
    end else if (bus_rd && !lat_q) begin
      rd_oe   <= 1'b1;
      rd_data <= ro_protect ? 8'h00 : arr_rdata[a_off*8 +: 8];
    end else begin
      rd_oe   <= 1'b0;
      rd_data <= 8'h00;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_undef
    always_ff @(posedge clk) begin
      if (rst) row_undef[r] <= 1'b0;
      else if (abort_stb && tgt_row == ROW_W'(r)) row_undef[r] <= 1'b1;
      else if (commit_stb && tgt_row == ROW_W'(r)) row_undef[r] <= 1'b0;
    end
  end

  always_comb begin
    csr_rdata = 8'h00;
    csr_rdata[CSR_PGM_BIT] = pgm;
    csr_rdata[CSR_LAT_BIT] = lat_q;
  end
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] csr_rdata,
  input logic       rd_oe,
  input logic [7:0] rd_data,
  input logic       ro_protect,
  input logic       in_wait,
  input logic       halt_req
);
  AST_CSR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[7:2] == 6'd0); // R2
  AST_PGM_NEEDS_LAT: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[0] |-> csr_rdata[1]); // R6
  AST_END_CLEARS_BOTH: assert property (@(posedge clk) disable iff (rst)
    $fell(csr_rdata[0]) |-> !csr_rdata[1]); // R6
  AST_NO_OE_IN_LAT: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> !$past(csr_rdata[1])); // R4
  AST_PROT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_oe && $past(ro_protect)) |-> rd_data == 8'h00); // R12
  AST_WAIT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    in_wait |-> !csr_rdata[0]); // R10
  AST_HALT_ABORTS: assert property (@(posedge clk) disable iff (rst)
    ($past(halt_req) && $past(csr_rdata[0])) |-> !csr_rdata[0]); // R11
endmodule

bind eeprom_row_writer eep_checker u_chk (
  .clk(clk), .rst(rst), .csr_rdata(csr_rdata), .rd_oe(rd_oe),
  .rd_data(rd_data), .ro_protect(ro_protect), .in_wait(in_wait),
  .halt_req(halt_req)
);

// File: tb/sim_eeprom_row_writer.sv
module sim_eeprom_row_writer;
  localparam int CYC = 16;
  localparam int ERS = 8;

  logic clk = 0, rst = 1;
  logic bus_en = 0, bus_wr = 0;
  logic [6:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, csr_wdata = 0;
  logic csr_we = 0, ro_protect = 0, wait_req = 0, halt_req = 0;
  logic rd_oe, in_wait, halted;
  logic [7:0] rd_data, csr_rdata;
  logic [3:0] row_undef;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [128];

  always #4 clk = ~clk;

  eeprom_row_writer #(.ROWS(4), .NBYTES(32), .CYC_CLKS(CYC), .ERASE_CLKS(ERS)) u0 (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_oe(rd_oe), .rd_data(rd_data), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ro_protect(ro_protect),
    .wait_req(wait_req), .in_wait(in_wait), .halt_req(halt_req), .halted(halted),
    .row_undef(row_undef)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(logic [7:0] v);
    @(negedge clk); csr_we = 1; csr_wdata = v;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic bus_w(int a, logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = 7'(a); bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_wr = 0;
  endtask

  task automatic bus_r(int a);
    @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = 7'(a);
    @(negedge clk); bus_en = 0;
  endtask

  task automatic run_cycle();
    csr_wr(8'h03);
    repeat (CYC) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(int a, int s);
    return 8'((a * 37 + s * 11 + 5) ^ (a >> 2));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R? actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 csr", csr_rdata, 0);
    chk("R1 rd_oe", rd_oe, 0);
    chk("R1 in_wait", in_wait, 0);
    chk("R1 halted", halted, 0);
    chk("R1 row_undef", row_undef, 0);

    // R6 fill every row with all 32 latches, timing checked on each row
    for (int r = 0; r < 4; r++) begin
      csr_wr(8'h02);
      chk("R2 lat bit1", csr_rdata, 8'h02);
      for (int i = 0; i < 32; i++) begin
        bus_w(r * 32 + i, pat(r * 32 + i, 1));
        model[r * 32 + i] = pat(r * 32 + i, 1);
      end
      csr_wr(8'h03);
      chk("R2 pgm bit0", csr_rdata, 8'h03);
      repeat (CYC - 1) @(negedge clk);
      chk("R6 still busy", csr_rdata, 8'h03);
      @(negedge clk);
      chk("R6 end clears both", csr_rdata, 8'h00);
    end
    // R3 sweep all bytes
    for (int a = 0; a < 128; a++) begin
      bus_r(a);
      chk("R3 oe", rd_oe, 1);
      chk("R3 data", rd_data, model[a]);
    end

    // R6 partial row, row from last latch write
    csr_wr(8'h02);
    for (int i = 0; i < 32; i += 3) begin
      bus_w(((i % 2) ? 0 : 96) + i, pat(i, 7));
    end
    bus_w(64 + 5, 8'h5A);
    for (int i = 0; i < 32; i += 3) model[64 + i] = pat(i, 7);
    model[64 + 5] = 8'h5A;
    run_cycle();
    for (int a = 0; a < 128; a++) begin
      bus_r(a);
      chk("R6 partial row", rd_data, model[a]);
    end

    // R7 AND of repeated latch writes
    csr_wr(8'h02);
    bus_w(32 + 4, 8'hA5);
    bus_w(32 + 4, 8'h3C);
    run_cycle();
    model[36] = 8'h24;
    bus_r(36); chk("R7 and", rd_data, 8'h24);
    bus_r(37); chk("R7 neighbour", rd_data, model[37]);

    // R4 read in latch mode, R3 write discarded in read mode
    csr_wr(8'h02);
    bus_w(10, 8'h99);
    bus_r(10); chk("R4 oe", rd_oe, 0); chk("R4 data", rd_data, 0);
    csr_wr(8'h00);
    bus_w(10, 8'h66);
    bus_r(10); chk("R3 discard", rd_data, model[10]);

    // R5 pgm without latch mode
    csr_wr(8'h01);
    chk("R5 no start", csr_rdata, 8'h00);

    // R8 falling edge clears latches
    csr_wr(8'h02);
    bus_w(96, 8'h00);
    csr_wr(8'h00);
    csr_wr(8'h02);
    bus_w(97, 8'h77);
    run_cycle();
    model[97] = 8'h77;
    bus_r(96); chk("R8 cleared latch", rd_data, model[96]);
    bus_r(97); chk("R8 new latch", rd_data, 8'h77);

    // R9 csr writes ignored during programming
    csr_wr(8'h02);
    bus_w(98, 8'h12);
    csr_wr(8'h03);
    csr_wr(8'h00);
    chk("R9 clear ignored", csr_rdata, 8'h03);
    repeat (CYC - 2) @(negedge clk);
    chk("R9 done", csr_rdata, 8'h00);
    model[98] = 8'h12;
    bus_r(98); chk("R9 programmed", rd_data, 8'h12);

    // R10 wait when idle
    @(negedge clk); wait_req = 1;
    @(negedge clk); chk("R10 idle wait", in_wait, 1);
    csr_wr(8'h02);
    chk("R10 csr ignored", csr_rdata, 8'h00);
    bus_r(0); chk("R10 read ignored", rd_oe, 0);
    wait_req = 0;
    @(negedge clk); chk("R10 leave", in_wait, 0);
    // R10 wait during a cycle
    csr_wr(8'h02);
    bus_w(99, 8'h34);
    csr_wr(8'h03);
    wait_req = 1;
    for (int k = 1; k < CYC; k++) begin
      @(negedge clk);
      chk("R10 busy no wait", in_wait, 0);
    end
    @(negedge clk);
    chk("R10 wait at end", in_wait, 1);
    chk("R10 pgm cleared", csr_rdata, 8'h00);
    wait_req = 0;
    @(negedge clk);
    model[99] = 8'h34;
    bus_r(99); chk("R10 completed", rd_data, 8'h34);

    // R11 / R13 halt before and after erase
    for (int t = 0; t < 2; t++) begin
      int m = (t == 0) ? 3 : 10;
      csr_wr(8'h02);
      for (int i = 0; i < 4; i++) bus_w(i, 8'h11 * (i + 1));
      csr_wr(8'h03);
      repeat (m) @(negedge clk);
      halt_req = 1;
      @(negedge clk);
      chk("R11 abort csr", csr_rdata, 8'h00);
      chk("R11 undef", row_undef, 4'b0001);
      chk("R11 halted", halted, 1);
      halt_req = 0;
      @(negedge clk);
      chk("R11 halted off", halted, 0);
      if (m + 1 > ERS) for (int i = 0; i < 4; i++) model[i] = 8'hFF;
      for (int i = 0; i < 6; i++) begin
        bus_r(i); chk("R13 erase state", rd_data, model[i]);
      end
    end
    csr_wr(8'h02);
    for (int i = 0; i < 32; i++) begin
      bus_w(i, pat(i, 9)); model[i] = pat(i, 9);
    end
    run_cycle();
    chk("R11 undef cleared", row_undef, 0);
    bus_r(3); chk("R11 reprogram", rd_data, model[3]);

    // R12 readout protect
    ro_protect = 1;
    bus_r(40); chk("R12 oe", rd_oe, 1); chk("R12 zero", rd_data, 0);
    ro_protect = 0;
    bus_r(40); chk("R12 off", rd_data, model[40]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule